// File: doc/BRIEF.md
# Acknowledge Slot Handler

This block handles the single acknowledge bit of a frame on a wired-AND serial bus where a low level (dominant) overrides a high level (recessive). Acknowledgement is collective and sits inside the frame. Every receiving node whose own CRC check passed pulls the line dominant for that one bit. The transmitting node leaves the line recessive and reads it back. If even one receiver drove dominant, the frame is acknowledged. A recessive read-back is an acknowledge error, and the surrounding logic answers it with an error frame and a retransmission.

A strobe marks the start of the acknowledge bit. At that strobe the handler captures whether this node is the transmitter and whether its CRC passed. A node that lost arbitration during the frame is treated as a receiver. For one bit time of `BIT_CYCLES` clocks, a receiver drives its answer on `txBit`. A transmitter samples `busRx` at clock `SAMPLE_PT` of the bit and reports the outcome with a one-clock pulse on `ackOk` or on `ackErr`. CRC computation, error-frame generation and retransmission belong to neighbouring blocks.

Top module: `ack_slot_handler`

## Requirements
- R1: After reset, `txBit` is 1 (recessive) and `ackOk` and `ackErr` are 0.
- R2: A receiver with `crcPass`=1 at the strobe drives `txBit`=0 for exactly `BIT_CYCLES` clocks. This starts in the clock after the strobe is sampled, and `txBit` returns to 1 afterwards.
- R3: A receiver with `crcPass`=0 at the strobe keeps `txBit` at 1 throughout the slot.
- R4: A transmitter keeps `txBit` at 1 throughout the slot, whatever `crcPass` is.
- R5: A transmitter that reads `busRx`=0 in slot clock `SAMPLE_PT` (clock 0 is the first clock after the strobe) raises `ackOk` for one clock, in slot clock `SAMPLE_PT`+1.
- R6: A transmitter that reads `busRx`=1 in slot clock `SAMPLE_PT` raises `ackErr` for one clock, in slot clock `SAMPLE_PT`+1.
- R7: `ackOk` and `ackErr` are never high together, each pulse lasts one clock, and at most one pulse occurs per slot.
- R8: A node acting as receiver never raises `ackOk` or `ackErr`.
- R9: With `lostArb`=1 at the strobe, the node acts as a receiver even when `roleTx`=1.
- R10: A strobe that arrives while a slot is in progress is ignored. The slot keeps its length and produces no second pulse.
- R11: The `busRx` level in any slot clock other than `SAMPLE_PT` has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| roleTx | input | 1 | 1 when this node transmitted the frame |
| lostArb | input | 1 | 1 when this node lost arbitration in the current frame |
| crcPass | input | 1 | 1 when this node's CRC check of the frame passed |
| slotStrobe | input | 1 | One-clock pulse marking the start of the acknowledge bit |
| busRx | input | 1 | Sampled bus level (0 dominant, 1 recessive) |
| txBit | output | 1 | Level this node drives on the bus (0 dominant) |
| ackOk | output | 1 | One-clock pulse: frame acknowledged |
| ackErr | output | 1 | One-clock pulse: acknowledge error |

## Verification
Suppose the captured role is wrong. A receiver then stays silent, or a transmitter pulls the bus dominant and acknowledges its own frame, and this shows on `txBit` in the first clock of the slot. A wrong slot counter shows at the end of the bit as a dominant pulse that is too short or too long, or it moves the outcome pulse away from clock `SAMPLE_PT`+1. The bench sweeps every combination of role, lost arbitration, CRC result, sampled level and a repeated strobe. It compares `txBit` and both pulses in every clock of each slot.

// File: rtl/ack_slot_pkg.sv
package ack_slot_pkg;

  // Strobes from the slot controller to the output datapath.
  typedef struct packed {
    logic driveDom;   // hold the line dominant in this clock
    logic sampleNow;  // read the bus back in this clock
    logic txSlot;     // slot in progress with this node as transmitter
  } ack_ctrl_t;

endpackage

// File: rtl/ack_slot_ctrl.sv
module ack_slot_ctrl
  import ack_slot_pkg::*;
#(
  parameter int BIT_CYCLES = 8,
  parameter int SAMPLE_PT  = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      roleTx,
  input  logic      lostArb,
  input  logic      crcPass,
  input  logic      slotStrobe,
  output ack_ctrl_t ctrl
);

  localparam int CW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] SAMPLE_CNT = CW'(SAMPLE_PT);

  typedef enum logic {ST_IDLE, ST_SLOT} slot_state_e;

  slot_state_e    state;
  logic [CW-1:0]  cnt;
  logic           slotTx;
  logic           slotCrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      slotTx  <= 1'b0;
      slotCrc <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (slotStrobe) begin
            state   <= ST_SLOT;
            cnt     <= '0;
            slotTx  <= roleTx & ~lostArb;
            slotCrc <= crcPass;
          end
        end
        ST_SLOT: begin
          if (cnt == LAST_CNT) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.driveDom  = (state == ST_SLOT) && !slotTx && slotCrc;
    ctrl.sampleNow = (state == ST_SLOT) && slotTx && (cnt == SAMPLE_CNT);
    ctrl.txSlot    = (state == ST_SLOT) && slotTx;
  end

  // R10: an active slot advances one clock at a time; a new strobe cannot restart it
  a_r10_slot_advances: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLOT && cnt != LAST_CNT) |=>
      (state == ST_SLOT && cnt == CW'($past(cnt) + 1'b1)));

  // R2: the slot ends right after its last clock
  a_r2_slot_ends: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLOT && cnt == LAST_CNT) |=> (state == ST_IDLE));

  // R9: a node that lost arbitration is captured as a receiver
  a_r9_lost_is_rx: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && slotStrobe && lostArb) |=> !slotTx);

endmodule

// File: rtl/ack_slot_dp.sv
module ack_slot_dp
  import ack_slot_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ack_ctrl_t ctrl,
  input  logic      busRx,
  output logic      txBit,
  output logic      ackOk,
  output logic      ackErr
);

  // The line is driven low only while a receiver acknowledges.
  assign txBit = ~ctrl.driveDom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackOk  <= 1'b0;
      ackErr <= 1'b0;
    end else begin
      ackOk  <= ctrl.sampleNow & ~busRx;
      ackErr <= ctrl.sampleNow &  busRx;
    end
  end

  // R7: outcome pulses are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ackOk && ackErr));

  // R7: each outcome pulse is a single clock
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (ackOk || ackErr) |=> !(ackOk || ackErr));

endmodule

// File: rtl/ack_slot_handler.sv
module ack_slot_handler
  import ack_slot_pkg::*;
#(
  parameter int BIT_CYCLES = 8,
  parameter int SAMPLE_PT  = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic roleTx,
  input  logic lostArb,
  input  logic crcPass,
  input  logic slotStrobe,
  input  logic busRx,
  output logic txBit,
  output logic ackOk,
  output logic ackErr
);

  ack_ctrl_t ctrlBus;

  ack_slot_ctrl #(
    .BIT_CYCLES(BIT_CYCLES),
    .SAMPLE_PT (SAMPLE_PT)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .roleTx    (roleTx),
    .lostArb   (lostArb),
    .crcPass   (crcPass),
    .slotStrobe(slotStrobe),
    .ctrl      (ctrlBus)
  );

  ack_slot_dp uDp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrlBus),
    .busRx (busRx),
    .txBit (txBit),
    .ackOk (ackOk),
    .ackErr(ackErr)
  );

  // R4: a transmitting node never drives dominant in its slot
  a_r4_tx_recessive: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.txSlot |-> txBit);

  // R8: outcome pulses only follow a transmitter slot
  a_r8_rx_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (ackOk || ackErr) |-> $past(ctrlBus.txSlot));

endmodule

// File: tb/tb_ack_slot_handler.sv
module tb_ack_slot_handler;

  localparam int BIT_CYCLES = 8;
  localparam int SAMPLE_PT  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic roleTx = 1'b0, lostArb = 1'b0, crcPass = 1'b0;
  logic slotStrobe = 1'b0, busRx = 1'b1;
  logic txBit, ackOk, ackErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ack_slot_handler #(.BIT_CYCLES(BIT_CYCLES), .SAMPLE_PT(SAMPLE_PT)) dut (
    .clk(clk), .rstN(rstN), .roleTx(roleTx), .lostArb(lostArb),
    .crcPass(crcPass), .slotStrobe(slotStrobe), .busRx(busRx),
    .txBit(txBit), .ackOk(ackOk), .ackErr(ackErr)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "txBit", txBit, 1'b1);
    check("R1", "ackOk", ackOk, 1'b0);
    check("R1", "ackErr", ackErr, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int combo = 0; combo < 32; combo++) begin
      automatic logic role = combo[0];
      automatic logic lost = combo[1];
      automatic logic crc  = combo[2];
      automatic logic lvl  = combo[3];
      automatic logic dbl  = combo[4];
      automatic logic isTx = role & ~lost;          // R9
      automatic logic drive = ~isTx & crc;          // R2, R3, R4
      automatic string reqTx = isTx ? "R4" : (crc ? "R2" : (lost && role ? "R9" : "R3"));
      automatic string reqP  = isTx ? (lvl ? "R6" : "R5") : "R8";

      roleTx = role; lostArb = lost; crcPass = crc; slotStrobe = 1'b1;
      @(negedge clk);
      slotStrobe = 1'b0;
      // inputs changed after capture must not matter
      roleTx = ~role; crcPass = ~crc;
      for (int c = 0; c < BIT_CYCLES + 3; c++) begin
        busRx = (c == SAMPLE_PT) ? lvl : ~lvl;     // R11: other clocks disagree
        slotStrobe = dbl && (c == 2);              // R10: strobe inside the slot
        #1;
        check((dbl && c >= BIT_CYCLES - 1) ? "R10" : reqTx, $sformatf("txBit clk %0d", c),
              txBit, (drive && c < BIT_CYCLES) ? 1'b0 : 1'b1);
        check(dbl ? "R10" : (c == SAMPLE_PT + 1 ? reqP : "R7"), $sformatf("ackOk clk %0d", c),
              ackOk, (isTx && !lvl && c == SAMPLE_PT + 1) ? 1'b1 : 1'b0);
        check(c == SAMPLE_PT + 1 ? "R11" : "R7", $sformatf("ackErr clk %0d", c),
              ackErr, (isTx && lvl && c == SAMPLE_PT + 1) ? 1'b1 : 1'b0);
        @(negedge clk);
      end
      slotStrobe = 1'b0;
      busRx = 1'b1;
      @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule